// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Address Bit

This block turns bytes into frames on an asynchronous serial line. The host presents a byte and an address-bit value with a one-cycle write strobe, and the block stores them in a one-entry holding register. Whenever the shift path is idle and the transmit enable is high, the held byte moves into a frame shift register. The frame is then sent one bit at a time. Each bit lasts sixteen pulses of an external baud tick.

Framing is chosen when the byte moves into the shift register. The options are an address bit after the data, a parity bit with even or odd sense (computed over the data and address bits), and one or two stop bits. A loopback option sends the serial stream to an internal receive tap and holds the external pin high. A synchronous active-low soft reset clears all transmit state.

Top module: `async_tx`

## Requirements
- R1: While `rst_n` or `softRstN` is 0, any frame in progress is abandoned and the held byte is dropped. On the next clock `busy`=0, `txPin`=1 and `loopTap`=1. `ready` reads 0 while `softRstN` is 0.
- R2: The idle line is 1. A frame is a 0 start bit, then the 8 data bits least significant first, then 1-valued stop bits. Each bit holds for 16 `baudTick` pulses.
- R3: With `addrMode`=1, the `wrAddr` value captured with the byte is sent as one extra bit right after data bit 7.
- R4: With `parityEn`=1, one parity bit follows the data bits (and the address bit, if present). With `parityEven`=1, the count of ones in data, address and parity bits is even. With `parityEven`=0, that count is odd. Start and stop bits are not counted.
- R5: `twoStop`=1 sends two stop bits. `twoStop`=0 sends one.
- R6: A write made while `txEn`=0 is discarded. `ready` does not change and nothing is sent.
- R7: A held byte moves to the shift register only while `txEn`=1. A byte left in the holding register waits while `txEn`=0 and is sent once `txEn` returns to 1.
- R8: Clearing `txEn` during a frame does not shorten it. The frame already loaded is sent to its last stop bit.
- R9: `ready` is 1 when the holding register is empty. It is 0 from the clock after an accepted write until the clock on which the byte moves into the shift register. A write to a full holding register replaces its contents.
- R10: With `loopEn`=1, `loopTap` carries the serial stream and `txPin` stays 1. With `loopEn`=0, `txPin` carries the stream and `loopTap` stays 1.
- R11: Frame options are sampled on the clock the byte enters the shift register. Later changes do not affect that frame.
- R12: A byte waiting in the holding register starts its frame one clock after the previous frame's last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| softRstN | input | 1 | Synchronous active-low soft reset |
| baudTick | input | 1 | One-cycle pulse, 16 per bit time |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Byte to transmit |
| wrAddr | input | 1 | Address-bit value stored with the byte |
| txEn | input | 1 | Transmit enable |
| addrMode | input | 1 | Insert address bit |
| parityEn | input | 1 | Insert parity bit |
| parityEven | input | 1 | 1 = even parity, 0 = odd parity |
| twoStop | input | 1 | 1 = two stop bits |
| loopEn | input | 1 | Internal loopback |
| txPin | output | 1 | External serial output |
| loopTap | output | 1 | Internal receive tap |
| ready | output | 1 | Holding register empty |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that `baudTick` is a single-cycle pulse and that the write strobe, the enable and the soft reset are sampled only at clock edges. They place no restriction on when the frame options change, because R11 makes those options matter only at the clock where the byte is loaded. The stimulus changes every input one time unit after a rising edge. It changes frame options in the middle of a frame on purpose, and it produces baud ticks on a fixed four-clock divider, so each bit lasts exactly 64 clocks.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef struct packed {
    logic clrAll;
    logic takeWrite;
    logic loadShift;
    logic shiftBit;
  } txStrobe_t;
endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      softRstN,
  input  logic      baudTick,
  input  logic      wrEn,
  input  logic      txEn,
  input  logic      holdValid,
  input  logic      addrMode,
  input  logic      parityEn,
  input  logic      twoStop,
  output txStrobe_t strobe,
  output logic      busy
);
  localparam int FRAME_W = DATA_W + 5;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BASE_LAST = BIT_W'(DATA_W + 1);

  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  lastIdx;
  logic              bitEnd;

  assign bitEnd = busy && baudTick && (tickCnt == TICK_LAST);

  always_comb begin
    strobe.clrAll    = !softRstN;
    strobe.takeWrite = softRstN && wrEn && txEn;
    strobe.loadShift = softRstN && !busy && holdValid && txEn;
    strobe.shiftBit  = softRstN && bitEnd && (bitCnt != lastIdx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitCnt  <= '0;
      lastIdx <= '0;
    end else if (!softRstN) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitCnt  <= '0;
      lastIdx <= '0;
    end else if (strobe.loadShift) begin
      busy    <= 1'b1;
      tickCnt <= '0;
      bitCnt  <= '0;
      lastIdx <= BASE_LAST + BIT_W'(addrMode) + BIT_W'(parityEn) + BIT_W'(twoStop);
    end else if (busy && baudTick) begin
      if (tickCnt == TICK_LAST) begin
        tickCnt <= '0;
        if (bitCnt == lastIdx) busy <= 1'b0;
        else bitCnt <= bitCnt + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrAddr,
  input  logic              addrMode,
  input  logic              parityEn,
  input  logic              parityEven,
  output logic              holdValid,
  output logic              serBit
);
  localparam int FRAME_W = DATA_W + 5;

  logic [DATA_W-1:0]  holdData;
  logic               holdAddr;
  logic [FRAME_W-1:0] shiftReg;

  function automatic logic [FRAME_W-1:0] buildFrame(
    input logic [DATA_W-1:0] d, input logic a, input logic am,
    input logic pe, input logic pev);
    logic [FRAME_W-1:0] f;
    logic par;
    par = (^d) ^ (am & a);
    if (!pev) par = ~par;
    f = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = d;
    if (am) begin
      f[DATA_W+1] = a;
      if (pe) f[DATA_W+2] = par;
    end else if (pe) begin
      f[DATA_W+1] = par;
    end
    return f;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      holdAddr  <= 1'b0;
    end else if (strobe.clrAll) begin
      holdValid <= 1'b0;
    end else if (strobe.takeWrite) begin
      holdValid <= 1'b1;
      holdData  <= wrData;
      holdAddr  <= wrAddr;
    end else if (strobe.loadShift) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftReg <= '1;
    else if (strobe.clrAll) shiftReg <= '1;
    else if (strobe.loadShift)
      shiftReg <= buildFrame(holdData, holdAddr, addrMode, parityEn, parityEven);
    else if (strobe.shiftBit) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
  end

  assign serBit = shiftReg[0];
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRstN,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrAddr,
  input  logic              txEn,
  input  logic              addrMode,
  input  logic              parityEn,
  input  logic              parityEven,
  input  logic              twoStop,
  input  logic              loopEn,
  output logic              txPin,
  output logic              loopTap,
  output logic              ready,
  output logic              busy
);
  txStrobe_t strobe;
  logic holdValid;
  logic serBit;
  logic line;

  async_tx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .softRstN(softRstN), .baudTick(baudTick),
    .wrEn(wrEn), .txEn(txEn), .holdValid(holdValid), .addrMode(addrMode),
    .parityEn(parityEn), .twoStop(twoStop), .strobe(strobe), .busy(busy)
  );

  async_tx_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .wrAddr(wrAddr), .addrMode(addrMode), .parityEn(parityEn),
    .parityEven(parityEven), .holdValid(holdValid), .serBit(serBit)
  );

  assign line    = busy ? serBit : 1'b1;
  assign txPin   = loopEn ? 1'b1 : line;
  assign loopTap = loopEn ? line : 1'b1;
  assign ready   = softRstN && !holdValid;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              softRstN,
  input logic              baudTick,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              wrAddr,
  input logic              txEn,
  input logic              addrMode,
  input logic              parityEn,
  input logic              parityEven,
  input logic              twoStop,
  input logic              loopEn,
  input logic              txPin,
  input logic              loopTap,
  input logic              ready,
  input logic              busy
);
  AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !softRstN |=> (!busy && txPin && loopTap)); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ((loopEn ? loopTap : txPin) == 1'b0)); // R2
  AST_BIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baudTick && softRstN) |=> busy); // R8
  AST_DISCARD_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (softRstN && wrEn && !txEn && ready) |=> (ready || !softRstN)); // R6
  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (softRstN && wrEn && txEn) |=> !ready); // R9
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !txEn) |=> !busy); // R7
  AST_LOOP_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    loopEn |-> txPin); // R10
  AST_TAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !loopEn |-> loopTap); // R10
endmodule

bind async_tx async_tx_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_async_tx.sv
`timescale 1ns/1ps
module test_async_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0, softRstN = 1'b0, baudTick = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic wrAddr = 1'b0, txEn = 1'b0, addrMode = 1'b0, parityEn = 1'b0;
  logic parityEven = 1'b0, twoStop = 1'b0, loopEn = 1'b0;
  logic txPin, loopTap, ready, busy;

  int checks = 0, errors = 0, cyc = 0, divCnt = 0;
  string curReq = "R1";
  bit started = 0;

  bit mHold = 0, mBusy = 0;
  logic [7:0] mHD = '0;
  bit mHA = 0;
  int mTick = 0;
  bit q[$];

  always #10 clk = ~clk;

  async_tx i_async_tx (
    .clk(clk), .rst_n(rst_n), .softRstN(softRstN), .baudTick(baudTick),
    .wrEn(wrEn), .wrData(wrData), .wrAddr(wrAddr), .txEn(txEn),
    .addrMode(addrMode), .parityEn(parityEn), .parityEven(parityEven),
    .twoStop(twoStop), .loopEn(loopEn), .txPin(txPin), .loopTap(loopTap),
    .ready(ready), .busy(busy)
  );

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  // baud tick: one pulse every 4 clocks
  always @(posedge clk) begin
    #1;
    divCnt = (divCnt + 1) % 4;
    baudTick = (divCnt == 0);
  end

  // behavioural reference model
  always @(posedge clk) begin
    bit wasBusy;
    int ones;
    if (!rst_n || !softRstN) begin
      mHold = 0; mBusy = 0; mTick = 0; q.delete();
    end else begin
      wasBusy = mBusy;
      if (mBusy && baudTick) begin
        mTick++;
        if (mTick == 16) begin
          mTick = 0;
          void'(q.pop_front());
          if (q.size() == 0) mBusy = 0;
        end
      end
      if (!wasBusy && mHold && txEn) begin
        q.push_back(1'b0);
        ones = 0;
        for (int i = 0; i < 8; i++) begin
          q.push_back(mHD[i]);
          ones += mHD[i];
        end
        if (addrMode) begin q.push_back(mHA); ones += mHA; end
        if (parityEn) q.push_back(parityEven ? (ones % 2 == 1) : (ones % 2 == 0));
        q.push_back(1'b1);
        if (twoStop) q.push_back(1'b1);
        mBusy = 1; mTick = 0; mHold = 0;
      end
      if (wrEn && txEn) begin mHD = wrData; mHA = wrAddr; mHold = 1; end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    bit line;
    if (started) begin
      line = mBusy ? q[0] : 1'b1;
      chk("txPin", txPin, loopEn ? 1'b1 : line);
      chk("loopTap", loopTap, loopEn ? line : 1'b1);
      chk("ready", ready, softRstN && !mHold);
      chk("busy", busy, mBusy);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] d, logic a);
    wrData = d; wrAddr = a; wrEn = 1'b1;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int k = 0;
    while ((mBusy || mHold) && k < 5000) begin step(1); k++; end
    step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    started = 1;
    step(2);
    curReq = "R1";
    chk("reset ready", ready, 1'b0);
    chk("reset busy", busy, 1'b0);
    chk("reset txPin", txPin, 1'b1);
    softRstN = 1'b1;
    step(1);
    chk("ready after soft reset release", ready, 1'b1);

    curReq = "R2"; txEn = 1'b1;
    wr(8'hA5, 1'b0); waitIdle();
    wr(8'h01, 1'b0); waitIdle();

    curReq = "R6"; txEn = 1'b0;
    wr(8'h3C, 1'b0);
    chk("ready after discarded write", ready, 1'b1);
    step(200);
    chk("busy after discarded write", busy, 1'b0);
    chk("line idle after discarded write", txPin, 1'b1);

    curReq = "R3"; txEn = 1'b1; addrMode = 1'b1;
    wr(8'h0F, 1'b1); waitIdle();
    wr(8'hF0, 1'b0); waitIdle();

    curReq = "R4"; parityEn = 1'b1; parityEven = 1'b1;
    wr(8'h07, 1'b1); waitIdle();
    parityEven = 1'b0;
    wr(8'h07, 1'b1); waitIdle();
    addrMode = 1'b0;
    wr(8'h5A, 1'b1); waitIdle();
    parityEven = 1'b1;
    wr(8'h80, 1'b0); waitIdle();

    curReq = "R5"; twoStop = 1'b1;
    wr(8'hC3, 1'b0); waitIdle();
    parityEn = 1'b0;
    wr(8'h00, 1'b0); waitIdle();
    twoStop = 1'b0;

    curReq = "R9";
    wr(8'h11, 1'b0);
    step(3);
    chk("ready after load", ready, 1'b1);
    wr(8'h22, 1'b0);
    chk("ready with hold full", ready, 1'b0);
    wr(8'h33, 1'b1);
    step(50);
    curReq = "R8"; txEn = 1'b0;
    step(800);
    chk("frame finished after disable", busy, 1'b0);
    curReq = "R7";
    chk("held byte waits while disabled", ready, 1'b0);
    txEn = 1'b1;
    step(2);
    chk("held byte starts on enable", busy, 1'b1);
    waitIdle();

    curReq = "R12";
    wr(8'h9E, 1'b0); step(2); wr(8'h61, 1'b1); waitIdle();

    curReq = "R10"; loopEn = 1'b1;
    wr(8'h6D, 1'b0); step(30);
    chk("pin high in loopback", txPin, 1'b1);
    waitIdle();
    loopEn = 1'b0;

    curReq = "R11";
    wr(8'hB2, 1'b1); step(100);
    addrMode = 1'b1; parityEn = 1'b1; twoStop = 1'b1; parityEven = 1'b0;
    waitIdle();
    addrMode = 1'b0; parityEn = 1'b0; twoStop = 1'b0;

    curReq = "R1";
    wr(8'h55, 1'b0); wr(8'hAA, 1'b0); step(100);
    softRstN = 1'b0; step(2);
    chk("busy in soft reset", busy, 1'b0);
    chk("ready in soft reset", ready, 1'b0);
    chk("txPin in soft reset", txPin, 1'b1);
    softRstN = 1'b1; step(200);
    chk("held byte dropped by soft reset", busy, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule